// File: doc/BRIEF.md
# Clock-Suspend Burst Datapath

This block is the device-side burst engine of a synchronous memory. It accepts a read or write command with a column address and then transfers a fixed-length burst, one beat per internal clock edge, against a small internal storage array. A registered clock-enable input lets the controller freeze the burst. While it is frozen, the internal edge is skipped, so the column counter, command decode and write capture do nothing. The read data output and its enable keep whatever they were driving.

The enable is sampled into a register on every rising edge. A low value seen on one edge suspends the next edge, not the current one. Each suspended edge makes the burst one cycle longer, and no beat is dropped or repeated. Suspension only applies while a burst is running. When the engine is idle, the clock-enable input has no effect and commands are decoded as usual.

Top module: `burst_suspend_engine`

## Requirements
- R1: The clock-enable input is registered on every rising edge, and that register resets to 1. A low sampled on edge N, while a burst is in progress, suspends edge N+1. Edge N itself still performs its beat.
- R2: On a suspended edge the beat counter does not advance. A burst with k suspended edges completes its BL beats in BL+k edges, in the same order as without suspension, with no beat lost or repeated.
- R3: On a suspended edge `rdata` and `rdata_oe` keep their previous values, so an active read output stays driven.
- R4: On a suspended edge `cmd`, `addr` and `wdata` are ignored, and no array location is written.
- R5: The beat order wraps inside the BL-aligned block of the start column. The column of beat k keeps the upper address bits of the start column and uses (start + k) mod BL as its low log2(BL) bits. BL is a parameter of 1, 2, 4 or 8 and defaults to 4.
- R6: The `cmd` encoding is 2'b01 READ, 2'b10 WRITE, and 2'b00 or 2'b11 NOP. A READ accepted on an idle edge drives beat 0 data on `rdata` with `rdata_oe`=1 right after that edge. Each later unsuspended edge presents the next beat. `rdata_oe` returns to 0 after the first unsuspended edge that follows the last beat, unless a new READ is accepted on that edge.
- R7: A WRITE accepted on an idle edge stores `wdata` of that edge as beat 0. The k-th following unsuspended edge stores `wdata` as beat k. `rdata_oe` stays 0 during writes.
- R8: Commands presented while a burst is in progress are ignored. The running burst is neither cut short nor restarted.
- R9: While no burst is in progress, a low clock-enable has no effect, and a command on that edge is accepted as usual.
- R10: After reset `rdata` is 0 and `rdata_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cke | input | 1 | Clock enable, registered every edge |
| cmd | input | 2 | Command: 01 read, 10 write, else no-op |
| addr | input | COL_W | Start column of a burst |
| wdata | input | DW | Write data for the current beat |
| rdata | output | DW | Read data of the current beat |
| rdata_oe | output | 1 | Read data valid / output drive enable |

## Verification
Plain bursts with the enable held high fill the whole array and read back a block from a start column inside it. This sets the baseline wrap order. Read bursts are then repeated with a single low enable, with two consecutive lows, and with a low on the command edge itself. Each beat is compared with the unsuspended order, which separates a one-edge delay from an immediate freeze and shows any lost or doubled beat. A write burst gets fresh data on every cycle, including the suspended ones, and a conflicting command on every busy cycle. A full readback afterwards shows whether frozen-edge data or mid-burst commands leaked into the array. Holding the enable low while idle and then issuing a read shows that idle decode is not gated.

// File: rtl/burst_suspend_engine.sv
module burst_suspend_engine #(
  parameter int DW    = 16,
  parameter int COL_W = 6,
  parameter int BL    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cke,
  input  logic [1:0]       cmd,
  input  logic [COL_W-1:0] addr,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  output logic             rdata_oe
);
  localparam int DEPTH = 1 << COL_W;
  localparam int CNT_W = (BL > 1) ? $clog2(BL) : 1;
  localparam logic [COL_W-1:0] MASK = COL_W'(BL - 1);
  localparam logic [1:0] OP_RD = 2'b01;
  localparam logic [1:0] OP_WR = 2'b10;

  logic [DW-1:0]    mem [DEPTH];
  logic             cke_q, busy, is_rd;
  logic [CNT_W-1:0] cnt;
  logic [COL_W-1:0] base;

  wire              frozen   = busy & ~cke_q;
  wire              start_rd = ~busy & (cmd == OP_RD);
  wire              start_wr = ~busy & (cmd == OP_WR);
  wire [CNT_W-1:0]  cnt_nxt  = cnt + 1'b1;
  wire              last     = (cnt_nxt == CNT_W'(BL - 1));
  wire [COL_W-1:0]  col_nxt  = (base & ~MASK) | ((base + COL_W'(cnt_nxt)) & MASK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cke_q    <= 1'b1;
      busy     <= 1'b0;
      is_rd    <= 1'b0;
      cnt      <= '0;
      base     <= '0;
      rdata    <= '0;
      rdata_oe <= 1'b0;
    end else begin
      cke_q <= cke;
      if (!frozen) begin
        if (busy) begin
          cnt      <= cnt_nxt;
          busy     <= ~last;
          rdata_oe <= is_rd;
          if (is_rd) rdata <= mem[col_nxt];
        end else if (start_rd || start_wr) begin
          base     <= addr;
          cnt      <= '0;
          busy     <= (BL > 1);
          is_rd    <= start_rd;
          rdata_oe <= start_rd;
          if (start_rd) rdata <= mem[addr];
        end else begin
          rdata_oe <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!frozen) begin
      if (busy && !is_rd) mem[col_nxt] <= wdata;
      else if (start_wr)  mem[addr]    <= wdata;
    end
  end
endmodule

// File: rtl/burst_suspend_chk.sv
module burst_suspend_chk #(
  parameter int DW    = 16,
  parameter int CNT_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       cmd,
  input logic             cke_q,
  input logic             busy,
  input logic [CNT_W-1:0] cnt,
  input logic [DW-1:0]    rdata,
  input logic             rdata_oe
);
  AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !cke_q |=> $stable(rdata) && $stable(rdata_oe)); // R3
  AST_FROZEN_NOCOUNT: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !cke_q |=> $stable(cnt) && busy); // R2
  AST_ACTIVE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cke_q |=> cnt != $past(cnt)); // R1
  AST_IDLE_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && cmd == 2'b01 |=> rdata_oe); // R9
  AST_OE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && rdata_oe && cmd != 2'b01 |=> !rdata_oe); // R6
endmodule

bind burst_suspend_engine burst_suspend_chk #(.DW(DW), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd(cmd), .cke_q(cke_q), .busy(busy),
  .cnt(cnt), .rdata(rdata), .rdata_oe(rdata_oe)
);

// File: tb/tb_burst_suspend_engine.sv
module tb_burst_suspend_engine;
  localparam int DW = 16, COL_W = 6, BL = 4, DEPTH = 1 << COL_W;

  logic clk = 0, rst_n = 0, cke = 1;
  logic [1:0] cmd = 2'b00;
  logic [COL_W-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic rdata_oe;

  int total = 0, bad = 0;
  logic [DW-1:0] mm [DEPTH];

  burst_suspend_engine #(.DW(DW), .COL_W(COL_W), .BL(BL)) dut (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cmd(cmd), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe));

  always #10 clk = ~clk;

  function automatic logic [COL_W-1:0] colf(input logic [COL_W-1:0] b, input int k);
    logic [COL_W-1:0] m = COL_W'(BL - 1);
    return (b & ~m) | ((b + COL_W'(k)) & m);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(rdata_oe == 1'b0, "R10 oe", DW'(rdata_oe), 0);
    chk(rdata == '0, "R10 rdata", rdata, 0);
    rst_n = 1;
  endtask

  task automatic do_write(input logic [COL_W-1:0] b, input logic [15:0] pat, input int n, input logic [DW-1:0] seed);
    int idx = 0;
    bit act;
    @(negedge clk);
    cmd = 2'b10; addr = b; cke = pat[0]; wdata = seed;
    mm[colf(b, 0)] = seed;
    act = (BL > 1);
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      chk(rdata_oe == 1'b0, "R7 oe low in write", DW'(rdata_oe), 0);
      if (i == n) break;
      cmd = act ? 2'b10 : 2'b00;
      addr = b ^ 6'h20;
      cke = pat[i];
      wdata = seed + DW'(i);
      if (!(!pat[i-1] && act) && act) begin
        idx++;
        mm[colf(b, idx)] = wdata;
        act = (idx < BL - 1);
      end
    end
    cmd = 2'b00; cke = 1;
  endtask

  task automatic do_read(input logic [COL_W-1:0] b, input logic [15:0] pat, input int n, input string tag);
    int idx = 0;
    bit act, eoe;
    logic [DW-1:0] ed;
    @(negedge clk);
    cmd = 2'b01; addr = b; cke = pat[0];
    ed = mm[colf(b, 0)]; eoe = 1; act = (BL > 1);
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      chk(rdata_oe == eoe, {tag, " oe"}, DW'(rdata_oe), DW'(eoe));
      if (eoe) chk(rdata == ed, {tag, " data"}, rdata, ed);
      if (i == n) break;
      cmd = act ? 2'b10 : 2'b00;
      addr = b ^ 6'h11;
      cke = pat[i];
      if (!(!pat[i-1] && act)) begin
        if (act) begin
          idx++;
          ed = mm[colf(b, idx)];
          eoe = 1;
          act = (idx < BL - 1);
        end else eoe = 0;
      end
    end
    cmd = 2'b00; cke = 1;
  endtask

  task automatic t_fill;
    for (int k = 0; k < DEPTH / BL; k++)
      do_write(COL_W'(k * BL), 16'hFFFF, BL + 1, DW'(16'hA000 + k * 16));
  endtask

  task automatic t_plain_read;
    do_read(6'd5, 16'hFFFF, 6, "R5 R6 wrap order");
    do_read(6'd12, 16'hFFFF, 6, "R6 aligned start");
  endtask

  task automatic t_suspend_read;
    do_read(6'd21, 16'hFFFB, 8, "R1 R3 single low");
    do_read(6'd30, 16'hFFF3, 9, "R2 R3 double low");
    do_read(6'd41, 16'hFFFE, 8, "R1 low on command edge");
    do_read(6'd47, 16'hFFD5, 12, "R2 scattered lows R8");
  endtask

  task automatic t_suspend_write;
    do_write(6'd9, 16'hFFED, 10, 16'h5100);
    do_write(6'd54, 16'hFFF9, 9, 16'h7700);
    do_read(6'd9, 16'hFFFF, 6, "R4 R7 frozen write data");
    do_read(6'd54, 16'hFFFF, 6, "R4 R7 second write");
  endtask

  task automatic t_idle_low;
    @(negedge clk); cke = 0; cmd = 2'b00;
    repeat (3) begin
      @(negedge clk);
      chk(rdata_oe == 1'b0, "R9 idle low oe", DW'(rdata_oe), 0);
    end
    do_read(6'd33, 16'hFFF0, 10, "R9 read under low enable");
  endtask

  task automatic t_readback;
    for (int k = 0; k < DEPTH / BL; k++)
      do_read(COL_W'(k * BL), 16'hFFFF, BL + 1, "R8 full readback");
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_reset;
    t_fill;
    t_plain_read;
    t_suspend_read;
    t_suspend_write;
    t_idle_low;
    t_readback;
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule